// File: doc/BRIEF.md
# Store Command Splitter

This unit sits between a processor-side request port and the memory-side command path. A store request carries a start address, a length code, a 16-bit byte-enable mask and a target memory type. The unit turns it into one or more write commands for that memory. A static-RAM target takes a 4-bit mask per command, and the unit splits a multi-longword store into single-longword commands when any enabled byte is off. A dynamic-RAM target works in 8-byte units with an 8-bit mask, and the unit splits a store along unit boundaries. Loads are not split: each one leaves as a single command.

Commands leave one per cycle on a valid/ready output. The input port is held not-ready until the last command of the current request has been taken. A request with an illegal length produces a one-cycle error pulse and is dropped.

Length codes are 0 byte, 1 word, 2 one longword, 3 two longwords, 4 three longwords, 5 four longwords, 6 eight longwords and 7 reserved. Memory select 0 means static RAM and 1 means dynamic RAM. Mask bit i enables byte i counted from the start address. Mask bits past the request length are ignored.

Top module: `store_splitter`

## Requirements
- R1: A byte, word or one-longword store gives exactly one command that keeps the input length code. For static RAM it carries the input address and mask bits 3:0 in out_mask[3:0]. For dynamic RAM it carries the address rounded down to 8 bytes, with the 4 mask bits placed in lanes 7:4 when address bit 2 is set and in lanes 3:0 otherwise.
- R2: A static-RAM store of two, three or four longwords whose enabled bytes are all on gives one command. That command has the input address and length and mask 0x0F.
- R3: A static-RAM store of two, three or four longwords with any enabled byte off gives one one-longword command (code 2) per longword. Command k carries the start address plus 4k and mask bits 4k+3..4k.
- R4: A dynamic-RAM two-longword store with address bit 2 clear gives one command with length code 3 and mask bits 7:0, whatever the mask.
- R5: A dynamic-RAM two-longword store with address bit 2 set gives two one-longword commands. The first goes to the rounded address with mask lanes 7:4 set from mask bits 3:0. The second goes to the rounded address plus 8 with lanes 3:0 set from mask bits 7:4.
- R6: A dynamic-RAM three-longword store always gives two commands, one per 8-byte unit, in ascending address order. A unit holding two longwords has length code 3 and a unit holding one has code 2. Each carries its 8 mask lanes.
- R7: A dynamic-RAM four-longword store from an 8-byte boundary gives one command (code 5, mask 0xFF) when every mask bit is on. Otherwise it gives two commands with code 3 at the base and base+8, carrying mask bits 7:0 and 15:8.
- R8: An illegal request raises err for the one cycle after acceptance and yields no command. The illegal requests are length code 7, a store of code 6, a load of codes 3 to 5, and a dynamic-RAM four-longword store with address bit 2 set.
- R9: A legal load gives one command with the input address, length and memory select, and mask 0.
- R10: in_ready is low whenever a command is pending. A command that is not taken stays on the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted when high with in_valid |
| in_load | input | 1 | 1 = load, 0 = store |
| in_dram | input | 1 | Target: 0 static RAM, 1 dynamic RAM |
| in_len | input | 3 | Length code |
| in_addr | input | ADDR_W | Start byte address |
| in_mask | input | 16 | Byte enables from the start address |
| out_valid | output | 1 | Command present |
| out_ready | input | 1 | Command taken when high with out_valid |
| out_load | output | 1 | Command is a load |
| out_dram | output | 1 | Command target |
| out_len | output | 3 | Command length code |
| out_addr | output | ADDR_W | Command address |
| out_mask | output | 8 | Command byte mask (static RAM uses bits 3:0) |
| err | output | 1 | Illegal request pulse |

## Verification
The bench uses the default 28-bit address. That width is narrow enough that directed requests near the top of the address space make the +4 and +8 command addresses wrap, and the reference model wraps them the same way. Random traffic mixes both memory types, all eight length codes, both word parities and full and partial masks. The output-ready back-pressure is random, so held commands and the stalled input are exercised at every command position.

// File: rtl/store_splitter.sv
module store_splitter #(
  parameter int ADDR_W = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_load,
  input  logic              in_dram,
  input  logic [2:0]        in_len,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [15:0]       in_mask,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_load,
  output logic              out_dram,
  output logic [2:0]        out_len,
  output logic [ADDR_W-1:0] out_addr,
  output logic [7:0]        out_mask,
  output logic              err
);

  logic              busy;
  logic [1:0]        idx, last_idx;
  logic [2:0]        r_len;
  logic [ADDR_W-1:0] r_addr;
  logic [15:0]       r_mask;
  logic [5:0]        r_lwv;
  logic              r_load, r_dram;

  logic [15:0] lm;
  logic [3:0]  lwbits;
  logic [1:0]  n_m1;
  logic        full, odd, illegal, accept;

  always_comb begin
    case (in_len)
      3'd3:    begin lm = 16'h00FF; lwbits = 4'b0011; end
      3'd4:    begin lm = 16'h0FFF; lwbits = 4'b0111; end
      3'd5:    begin lm = 16'hFFFF; lwbits = 4'b1111; end
      default: begin lm = 16'h000F; lwbits = 4'b0001; end
    endcase
  end

  assign full    = &(in_mask | ~lm);
  assign odd     = in_addr[2];
  assign illegal = (in_len == 3'd7) ||
                   (in_load ? (in_len >= 3'd3 && in_len <= 3'd5)
                            : (in_len == 3'd6 || (in_dram && in_len == 3'd5 && odd)));

  always_comb begin
    n_m1 = 2'd0;
    if (!in_load && in_len >= 3'd3 && in_len <= 3'd5) begin
      if (!in_dram) n_m1 = full ? 2'd0 : in_len[1:0] - 2'd2;
      else case (in_len)
        3'd3:    n_m1 = odd ? 2'd1 : 2'd0;
        3'd4:    n_m1 = 2'd1;
        default: n_m1 = full ? 2'd0 : 2'd1;
      endcase
    end
  end

  assign in_ready  = !busy;
  assign accept    = in_valid && in_ready;
  assign out_valid = busy;
  assign out_load  = r_load;
  assign out_dram  = r_dram;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; idx <= '0; last_idx <= '0; err <= 1'b0;
      r_len <= '0; r_addr <= '0; r_mask <= '0; r_lwv <= '0;
      r_load <= 1'b0; r_dram <= 1'b0;
    end else begin
      err <= accept && illegal;
      if (accept && !illegal) begin
        busy     <= 1'b1;
        idx      <= '0;
        last_idx <= n_m1;
        r_len    <= in_len;
        r_addr   <= in_addr;
        r_mask   <= in_mask & lm;
        r_lwv    <= {2'b00, lwbits} << odd;
        r_load   <= in_load;
        r_dram   <= in_dram;
      end else if (busy && out_ready) begin
        if (idx == last_idx) begin
          busy <= 1'b0;
          idx  <= '0;
        end else begin
          idx <= idx + 2'd1;
        end
      end
    end
  end

  logic [23:0]       win;
  logic [ADDR_W-1:0] base;
  logic              split;

  assign win   = r_addr[2] ? {4'b0, r_mask, 4'b0} : {8'b0, r_mask};
  assign base  = {r_addr[ADDR_W-1:3], 3'b000};
  assign split = last_idx != 2'd0;

  always_comb begin
    out_len  = r_len;
    out_addr = r_addr;
    out_mask = 8'h00;
    if (!r_load) begin
      if (!r_dram) begin
        if (split) begin
          out_len  = 3'd2;
          out_addr = r_addr + ADDR_W'({idx, 2'b00});
          out_mask = {4'b0, r_mask[{idx, 2'b00} +: 4]};
        end else begin
          out_mask = (r_len <= 3'd2) ? {4'b0, r_mask[3:0]} : 8'h0F;
        end
      end else begin
        out_addr = base + ADDR_W'({idx, 3'b000});
        out_mask = win[{idx, 3'b000} +: 8];
        if (split) out_len = (r_lwv[{idx, 1'b0} +: 2] == 2'b11) ? 3'd3 : 3'd2;
      end
    end
  end

endmodule

// File: rtl/store_splitter_chk.sv
module store_splitter_chk #(
  parameter int ADDR_W = 28
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_load,
  input logic              out_dram,
  input logic [2:0]        out_len,
  input logic [ADDR_W-1:0] out_addr,
  input logic [7:0]        out_mask,
  input logic              err
);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_mask) && $stable(out_len));

  p_busy_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  p_err_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(in_valid && in_ready));

  p_err_nocmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !out_valid);

  p_sram_width_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_dram |-> out_mask[7:4] == 4'h0);

  p_dram_align_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_dram && !out_load |-> out_addr[2:0] == 3'b000);

  p_load_nomask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_load |-> out_mask == 8'h00);

endmodule

bind store_splitter store_splitter_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_store_splitter.sv
module tb_store_splitter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_load = 1'b0, in_dram = 1'b0;
  logic [2:0]  in_len = '0;
  logic [27:0] in_addr = '0;
  logic [15:0] in_mask = '0;
  logic        out_ready = 1'b0;
  logic        in_ready, out_valid, out_load, out_dram, err;
  logic [2:0]  out_len;
  logic [27:0] out_addr;
  logic [7:0]  out_mask;

  always #5 clk = ~clk;

  store_splitter #(.ADDR_W(28)) dut (.*);

  int total = 0, bad = 0;
  logic [27:0] e_addr [4];
  logic [2:0]  e_len  [4];
  logic [7:0]  e_mask [4];
  int          e_n;
  bit          e_err;
  string       e_req;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic void add(input logic [27:0] a, input logic [2:0] l, input logic [7:0] m);
    e_addr[e_n] = a; e_len[e_n] = l; e_mask[e_n] = m; e_n++;
  endfunction

  function automatic void model(input bit ld, input bit dr, input logic [2:0] len,
                                input logic [27:0] a, input logic [15:0] m);
    int nlw;
    logic [15:0] mm;
    logic [23:0] w;
    logic [5:0]  v;
    logic [27:0] b;
    bit fl;
    e_n = 0; e_err = 0;
    if (len == 7 || (ld && len >= 3 && len <= 5) || (!ld && len == 6) || (!ld && dr && len == 5 && a[2])) begin
      e_err = 1; e_req = "R8"; return;
    end
    if (ld) begin e_req = "R9"; add(a, len, 8'h00); return; end
    nlw = (len <= 2) ? 1 : len - 1;
    mm  = m & 16'((32'h1 << (4 * nlw)) - 1);
    fl  = (mm == 16'((32'h1 << (4 * nlw)) - 1));
    if (!dr) begin
      if (nlw == 1) begin e_req = "R1"; add(a, len, {4'h0, m[3:0]}); end
      else if (fl) begin e_req = "R2"; add(a, len, 8'h0F); end
      else begin
        e_req = "R3";
        for (int k = 0; k < nlw; k++) add(a + 28'(4 * k), 3'd2, {4'h0, m[4*k +: 4]});
      end
    end else begin
      b = {a[27:3], 3'b000};
      w = a[2] ? {4'h0, mm, 4'h0} : {8'h0, mm};
      v = 6'(((1 << nlw) - 1) << a[2]);
      if (nlw == 1) begin e_req = "R1"; add(b, len, w[7:0]); end
      else if (nlw == 4 && fl) begin e_req = "R7"; add(b, 3'd5, 8'hFF); end
      else begin
        e_req = (nlw == 2) ? (a[2] ? "R5" : "R4") : (nlw == 3 ? "R6" : "R7");
        for (int u = 0; u < 3; u++)
          if (v[2*u +: 2] != 2'b00) add(b + 28'(8 * u), (v[2*u +: 2] == 2'b11) ? 3'd3 : 3'd2, w[8*u +: 8]);
        if (e_n == 1) e_len[0] = len;
      end
    end
  endfunction

  task automatic run(input bit ld, input bit dr, input logic [2:0] len,
                     input logic [27:0] a, input logic [15:0] m);
    int k, guard;
    model(ld, dr, len, a, m);
    @(negedge clk);
    in_valid = 1; in_load = ld; in_dram = dr; in_len = len; in_addr = a; in_mask = m; out_ready = 0;
    @(posedge clk); #1 in_valid = 0;
    @(negedge clk);
    chk("R8", "err", err, e_err);
    if (e_err) begin chk("R8", "no command", out_valid, 0); return; end
    k = 0; guard = 0;
    while (k < e_n && guard < 100) begin
      chk(e_req, "valid", out_valid, 1);
      chk("R10", "ready low", in_ready, 0);
      chk(e_req, "addr", out_addr, e_addr[k]);
      chk(e_req, "len", out_len, e_len[k]);
      chk(e_req, "mask", out_mask, e_mask[k]);
      chk(e_req, "kind", {out_load, out_dram}, {ld, dr});
      out_ready = ($urandom % 3) != 0;
      @(posedge clk);
      if (out_ready) k++;
      @(negedge clk);
      guard++;
    end
    out_ready = 0;
    chk(e_req, "no extra command", out_valid, 0);
    chk("R10", "ready back", in_ready, 1);
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unused;
    unused = $urandom(32'd2024);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R10", "reset valid", out_valid, 0);
    chk("R10", "reset ready", in_ready, 1);
    chk("R8", "reset err", err, 0);

    run(0, 0, 3'd0, 28'h0000104, 16'h0002);   // R1 byte sram
    run(0, 1, 3'd2, 28'h0000104, 16'h000F);   // R1 dram odd lanes
    run(0, 1, 3'd1, 28'h0000200, 16'h0003);   // R1 dram even lanes
    run(0, 0, 3'd5, 28'h0000300, 16'hFFFF);   // R2
    run(0, 0, 3'd3, 28'h0000310, 16'h00FF);   // R2
    run(0, 0, 3'd4, 28'h0000320, 16'h0EFF);   // R3
    run(0, 0, 3'd5, 28'hFFFFFF8, 16'hFF7F);   // R3 wrap
    run(0, 1, 3'd3, 28'h0000400, 16'h0012);   // R4
    run(0, 1, 3'd3, 28'h0000404, 16'h00A5);   // R5
    run(0, 1, 3'd4, 28'h0000500, 16'h0FFF);   // R6 even
    run(0, 1, 3'd4, 28'hFFFFFFC, 16'h0F3F);   // R6 odd wrap
    run(0, 1, 3'd5, 28'h0000600, 16'hFFFF);   // R7 full
    run(0, 1, 3'd5, 28'h0000608, 16'hFFF7);   // R7 partial
    run(0, 1, 3'd5, 28'h0000604, 16'hFFFF);   // R8 odd four
    run(0, 0, 3'd6, 28'h0000700, 16'hFFFF);   // R8 store eight
    run(1, 0, 3'd4, 28'h0000700, 16'hFFFF);   // R8 load three
    run(1, 1, 3'd7, 28'h0000700, 16'hFFFF);   // R8 reserved
    run(1, 0, 3'd6, 28'h0000800, 16'hFFFF);   // R9
    run(1, 1, 3'd0, 28'h0000803, 16'h1234);   // R9

    for (int i = 0; i < 600; i++) begin
      logic [15:0] m;
      m = ($urandom % 2) ? 16'hFFFF : 16'($urandom);
      run(($urandom % 5) == 0, $urandom % 2, 3'($urandom), {28'($urandom) >> 2, 2'b00}, m);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule